// File: doc/BRIEF.md
# Branch and Skip Next-PC Unit

This unit holds the program counter of a small 8-bit core and chooses its next value each time the core executes one instruction. The decoder hands it a 4-bit operation code, an absolute target index, three status flags (carry, zero, sign) and the two register operands of a compare. From these it picks one of three outcomes: load the target, step over the following instruction, or move on by one. Every operation code that is not a control transfer counts as "move on by one".

The unit also decides when execution stops. A program length is captured when a new program is loaded. The run halts while the PC lies at or beyond that length, or once a saturating count of executed instructions reaches a configured ceiling. While halted, step requests have no effect. Loading a program clears both the PC and the count, and it takes priority over a step in the same cycle.

Top module: `branch_skip_unit`

## Requirements
- R1: After reset, `pc_o` is 0, `cyc_o` is 0 and the captured length is 0, so `halt_o` is 1.
- R2: A cycle with `load_i` high clears `pc_o` and `cyc_o` and captures `prog_len_i` as the program length.
- R3: An executed step with op 1 (jump) loads `pc_o` with `target_i`, zero-extended.
- R4: Op 2 branches to the target when `carry_i` is 0, and op 3 branches when `carry_i` is 1. Otherwise the PC advances by one.
- R5: Op 4 branches to the target when `zero_i` is 1, and op 5 branches when `zero_i` is 0. Otherwise the PC advances by one.
- R6: Op 6 (signed greater-or-equal) branches when `sign_i` is 0, and op 7 (signed less-than) branches when `sign_i` is 1. Otherwise the PC advances by one.
- R7: Op 8 (compare and skip) advances the PC by two when `rd_val_i` equals `rr_val_i`, and by one when they differ.
- R8: Op 0 and every op code from 9 to 15 advance the PC by one, whatever the target and flags are.
- R9: `halt_o` is 1 while `pc_o` is at or above the captured length. A step request during a halt leaves `pc_o` and `cyc_o` unchanged.
- R10: `cyc_o` increases by one for each executed step. It saturates at `MAX_CYCLES`, and reaching that value raises `halt_o`.
- R11: When `load_i` and `step_i` are both high in the same cycle, the load wins: `pc_o` and `cyc_o` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | A new program was loaded; clears PC and count |
| prog_len_i | input | PC_W+1 | Number of instructions in the loaded program, captured on load |
| step_i | input | 1 | Execute the instruction at the current PC |
| op_i | input | 4 | Control operation code of that instruction |
| target_i | input | PC_W | Absolute target index for jump and branch codes |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| sign_i | input | 1 | Sign flag (negative xor overflow) |
| rd_val_i | input | DATA_W | First compare operand |
| rr_val_i | input | DATA_W | Second compare operand |
| pc_o | output | PC_W+1 | Current program counter |
| halt_o | output | 1 | Execution stopped (PC out of range or count at ceiling) |
| cyc_o | output | CYC_W | Saturating count of executed instructions |

## Verification
Each branch code is driven both taken and not taken, with the unrelated flags set opposite, so a design that tested the wrong flag bit or swapped a polarity lands on the wrong PC. Compare-and-skip uses operands that differ in a single bit; an equality check that is too loose would skip when it should not. The bench steps onto the last instruction and then steps again, and it also jumps past the program end, so an off-by-one in the range check would keep running or stop early. It drives the count to its ceiling and asserts load and step together, which exposes a counter that wraps, a halt that ignores the ceiling, or a step that wins over a load.

// File: rtl/bsu_pkg.sv
// Package: shared operation codes and helpers for the branch/skip unit.
// Assumes the decoder produces these 4-bit codes; unlisted codes are plain instructions.
package bsu_pkg;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_JUMP  = 4'd1,
        OP_BCCLR = 4'd2,
        OP_BCSET = 4'd3,
        OP_BZSET = 4'd4,
        OP_BZCLR = 4'd5,
        OP_BSGE  = 4'd6,
        OP_BSLT  = 4'd7,
        OP_SKEQ  = 4'd8
    } ctl_op_e;

    // Advance amounts for the sequential path
    localparam int unsigned STEP_ONE = 1;
    localparam int unsigned STEP_TWO = 2;

endpackage

// File: rtl/bsu_cond.sv
// Module: bsu_cond
// Resolves a control operation code into "load target" or "skip next".
// Assumes flags and operands are stable for the cycle in which the step is taken.
module bsu_cond
    import bsu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [3:0]        op_i,
    input  logic              carry_i,
    input  logic              zero_i,
    input  logic              sign_i,
    input  logic [DATA_W-1:0] rd_val_i,
    input  logic [DATA_W-1:0] rr_val_i,
    output logic              take_o,
    output logic              skip_o
);

    logic operands_equal;

    // Equality of the two compare operands
    always_comb begin
        operands_equal = (rd_val_i == rr_val_i);
    end

    // Map the operation code and flags onto the two outcomes
    always_comb begin
        take_o = 1'b0;
        skip_o = 1'b0;
        case (op_i)
            OP_JUMP:  take_o = 1'b1;
            OP_BCCLR: take_o = ~carry_i;
            OP_BCSET: take_o = carry_i;
            OP_BZSET: take_o = zero_i;
            OP_BZCLR: take_o = ~zero_i;
            OP_BSGE:  take_o = ~sign_i;
            OP_BSLT:  take_o = sign_i;
            OP_SKEQ:  skip_o = operands_equal;
            default: begin
                take_o = 1'b0;
                skip_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bsu_next.sv
// Module: bsu_next
// Forms the candidate next PC from the current PC and the resolved outcome.
// Assumes the PC is one bit wider than the target so PC+2 never wraps.
module bsu_next
    import bsu_pkg::*;
#(
    parameter int unsigned PC_W = 8,
    localparam int unsigned PCX_W = PC_W + 1
) (
    input  logic [PCX_W-1:0] pc_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic             take_i,
    input  logic             skip_i,
    output logic [PCX_W-1:0] next_o
);

    logic [PCX_W-1:0] advance;

    // Sequential advance: one normally, two when skipping
    always_comb begin
        advance = skip_i ? PCX_W'(STEP_TWO) : PCX_W'(STEP_ONE);
    end

    // Branch target takes priority over the sequential path
    always_comb begin
        if (take_i) next_o = {1'b0, target_i};
        else        next_o = pc_i + advance;
    end

endmodule

// File: rtl/bsu_limit.sv
// Module: bsu_limit
// Keeps the program length and a saturating executed-instruction count, and
// computes the stop condition. Assumes load has priority over execution.
module bsu_limit #(
    parameter int unsigned PC_W       = 8,
    parameter int unsigned MAX_CYCLES = 100000,
    localparam int unsigned PCX_W = PC_W + 1,
    localparam int unsigned CYC_W = $clog2(MAX_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [PCX_W-1:0] prog_len_i,
    input  logic             exec_i,
    input  logic [PCX_W-1:0] pc_i,
    output logic [CYC_W-1:0] cyc_o,
    output logic             halt_o
);

    localparam logic [CYC_W-1:0] CYC_MAX = CYC_W'(MAX_CYCLES);

    logic [PCX_W-1:0] len_q;
    logic [CYC_W-1:0] cyc_q;
    logic             at_ceiling;

    // Capture the program length on each load
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= '0;
        else if (load_i) len_q <= prog_len_i;
    end

    // Count executed instructions, saturating at the ceiling
    always_ff @(posedge clk) begin
        if (!rst_n)                     cyc_q <= '0;
        else if (load_i)                cyc_q <= '0;
        else if (exec_i && !at_ceiling) cyc_q <= cyc_q + 1'b1;
    end

    // Stop when out of program range or at the count ceiling
    always_comb begin
        at_ceiling = (cyc_q >= CYC_MAX);
        halt_o     = (pc_i >= len_q) || at_ceiling;
        cyc_o      = cyc_q;
    end

endmodule

// File: rtl/branch_skip_unit.sv
// Module: branch_skip_unit (top)
// Holds the PC and advances it per executed instruction: jump, conditional
// branch, compare-and-skip or plain step. Assumes one instruction per step_i.
module branch_skip_unit #(
    parameter int unsigned PC_W       = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned MAX_CYCLES = 100000,
    localparam int unsigned PCX_W = PC_W + 1,
    localparam int unsigned CYC_W = $clog2(MAX_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PCX_W-1:0]  prog_len_i,
    input  logic              step_i,
    input  logic [3:0]        op_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic              carry_i,
    input  logic              zero_i,
    input  logic              sign_i,
    input  logic [DATA_W-1:0] rd_val_i,
    input  logic [DATA_W-1:0] rr_val_i,
    output logic [PCX_W-1:0]  pc_o,
    output logic              halt_o,
    output logic [CYC_W-1:0]  cyc_o
);

    logic [PCX_W-1:0] pc_q;
    logic [PCX_W-1:0] pc_next;
    logic             take;
    logic             skip;
    logic             halted;
    logic             exec;

    bsu_cond #(.DATA_W(DATA_W)) i_cond (
        .op_i     (op_i),
        .carry_i  (carry_i),
        .zero_i   (zero_i),
        .sign_i   (sign_i),
        .rd_val_i (rd_val_i),
        .rr_val_i (rr_val_i),
        .take_o   (take),
        .skip_o   (skip)
    );

    bsu_next #(.PC_W(PC_W)) i_next (
        .pc_i     (pc_q),
        .target_i (target_i),
        .take_i   (take),
        .skip_i   (skip),
        .next_o   (pc_next)
    );

    bsu_limit #(.PC_W(PC_W), .MAX_CYCLES(MAX_CYCLES)) i_limit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .prog_len_i (prog_len_i),
        .exec_i     (exec),
        .pc_i       (pc_q),
        .cyc_o      (cyc_o),
        .halt_o     (halted)
    );

    // An instruction executes only when requested, not halted and not loading
    always_comb begin
        exec = step_i && !halted && !load_i;
    end

    // PC register: load clears it, execution advances it
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (load_i) pc_q <= '0;
        else if (exec)   pc_q <= pc_next;
    end

    // Drive outputs
    always_comb begin
        pc_o   = pc_q;
        halt_o = halted;
    end

endmodule

// File: rtl/bsu_checker.sv
// Module: bsu_checker
// Temporal checks on the ports of branch_skip_unit, attached by bind.
module bsu_checker #(
    parameter int unsigned PC_W       = 8,
    parameter int unsigned MAX_CYCLES = 100000,
    localparam int unsigned PCX_W = PC_W + 1,
    localparam int unsigned CYC_W = $clog2(MAX_CYCLES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             step_i,
    input logic [3:0]       op_i,
    input logic [PC_W-1:0]  target_i,
    input logic [PCX_W-1:0] pc_o,
    input logic             halt_o,
    input logic [CYC_W-1:0] cyc_o
);

    // R2
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (pc_o == '0 && cyc_o == '0));

    // R3
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !halt_o && op_i == 4'd1) |=> pc_o == {1'b0, $past(target_i)});

    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !load_i) |=> ($stable(pc_o) && $stable(cyc_o)));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !halt_o) |=> cyc_o == $past(cyc_o) + 1'b1);

    // R10
    count_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_o <= CYC_W'(MAX_CYCLES)) && (cyc_o == CYC_W'(MAX_CYCLES) -> halt_o));

    // R11
    load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && step_i) |=> pc_o == '0);

endmodule

bind branch_skip_unit bsu_checker #(.PC_W(PC_W), .MAX_CYCLES(MAX_CYCLES)) i_bsu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .step_i   (step_i),
    .op_i     (op_i),
    .target_i (target_i),
    .pc_o     (pc_o),
    .halt_o   (halt_o),
    .cyc_o    (cyc_o)
);

// File: tb/test_branch_skip_unit.sv
module test_branch_skip_unit;

    localparam int unsigned PC_W   = 8;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned MAXC   = 12;
    localparam int unsigned PCX_W  = PC_W + 1;
    localparam int unsigned CYC_W  = $clog2(MAXC + 1);

    typedef struct packed {
        logic [3:0]        op;
        logic [PC_W-1:0]   tgt;
        logic              c;
        logic              z;
        logic              s;
        logic [DATA_W-1:0] rd;
        logic [DATA_W-1:0] rr;
        logic [PCX_W-1:0]  exp;
    } vec_t;

    localparam int NV = 17;
    // Each vector starts from PC 10 in a 200-entry program.
    localparam vec_t VECS [NV] = '{
        '{4'd1,  8'd77, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 9'd77},
        '{4'd2,  8'd40, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 9'd40},
        '{4'd2,  8'd40, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 9'd11},
        '{4'd3,  8'd50, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 9'd50},
        '{4'd3,  8'd50, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 9'd11},
        '{4'd4,  8'd60, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 9'd60},
        '{4'd4,  8'd60, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 9'd11},
        '{4'd5,  8'd70, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 9'd70},
        '{4'd5,  8'd70, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 9'd11},
        '{4'd6,  8'd30, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 9'd30},
        '{4'd6,  8'd30, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 9'd11},
        '{4'd7,  8'd5,  1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 9'd5},
        '{4'd7,  8'd5,  1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 9'd11},
        '{4'd8,  8'd90, 1'b1, 1'b1, 1'b1, 8'h5A, 8'h5A, 9'd12},
        '{4'd8,  8'd90, 1'b0, 1'b1, 1'b0, 8'h5A, 8'h5B, 9'd11},
        '{4'd0,  8'd99, 1'b1, 1'b1, 1'b1, 8'h11, 8'h11, 9'd11},
        '{4'd15, 8'd99, 1'b0, 1'b0, 1'b1, 8'h22, 8'h22, 9'd11}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              load_i;
    logic [PCX_W-1:0]  prog_len_i;
    logic              step_i;
    logic [3:0]        op_i;
    logic [PC_W-1:0]   target_i;
    logic              carry_i, zero_i, sign_i;
    logic [DATA_W-1:0] rd_val_i, rr_val_i;
    logic [PCX_W-1:0]  pc_o;
    logic              halt_o;
    logic [CYC_W-1:0]  cyc_o;

    int checks = 0;
    int fails  = 0;
    int ticks  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    branch_skip_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .MAX_CYCLES(MAXC)) i_branch_skip_unit (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .prog_len_i(prog_len_i),
        .step_i(step_i), .op_i(op_i), .target_i(target_i), .carry_i(carry_i),
        .zero_i(zero_i), .sign_i(sign_i), .rd_val_i(rd_val_i), .rr_val_i(rr_val_i),
        .pc_o(pc_o), .halt_o(halt_o), .cyc_o(cyc_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1:       return "R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8:       return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One executed cycle: drive at the falling edge, leave outputs settled after the rising edge
    task automatic pulse(input logic ld, input logic st, input logic [3:0] op,
                         input logic [PC_W-1:0] tgt, input logic c, input logic z,
                         input logic s, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
        @(negedge clk);
        load_i = ld; step_i = st; op_i = op; target_i = tgt;
        carry_i = c; zero_i = z; sign_i = s; rd_val_i = a; rr_val_i = b;
        @(negedge clk);
        load_i = 1'b0; step_i = 1'b0;
    endtask

    task automatic load_prog(input int len);
        prog_len_i = PCX_W'(len);
        pulse(1'b1, 1'b0, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic nop_step();
        pulse(1'b0, 1'b1, 4'd0, '0, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    // Watchdog
    always @(posedge clk) begin
        ticks++;
        if (ticks > 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", ticks, 20000);
            report();
        end
    end

    initial begin
        rst_n = 1'b0; load_i = 1'b0; step_i = 1'b0; prog_len_i = '0; op_i = '0;
        target_i = '0; carry_i = 1'b0; zero_i = 1'b0; sign_i = 1'b0;
        rd_val_i = '0; rr_val_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", "pc after reset", pc_o, 0);
        check("R1", "count after reset", cyc_o, 0);
        check("R1", "halt after reset", halt_o, 1);

        // R9: step before any load is ignored
        nop_step();
        check("R9", "pc with empty program", pc_o, 0);
        check("R9", "count with empty program", cyc_o, 0);

        // Vector table: load, jump to 10, then the instruction under test
        for (int i = 0; i < NV; i++) begin
            load_prog(200);
            pulse(1'b0, 1'b1, 4'd1, 8'd10, 1'b0, 1'b0, 1'b0, '0, '0);
            pulse(1'b0, 1'b1, VECS[i].op, VECS[i].tgt, VECS[i].c, VECS[i].z,
                  VECS[i].s, VECS[i].rd, VECS[i].rr);
            check(req_of(VECS[i].op), $sformatf("vector %0d pc", i), pc_o, VECS[i].exp);
            check("R10", $sformatf("vector %0d count", i), cyc_o, 2);
        end

        // R2: load clears PC and count
        load_prog(200);
        check("R2", "pc after load", pc_o, 0);
        check("R2", "count after load", cyc_o, 0);

        // R9: stepping onto and past the last instruction
        load_prog(3);
        nop_step(); nop_step();
        check("R9", "not halted on last instruction", halt_o, 0);
        nop_step();
        check("R9", "pc at program end", pc_o, 3);
        check("R9", "halt at program end", halt_o, 1);
        nop_step();
        check("R9", "pc frozen while halted", pc_o, 3);
        check("R9", "count frozen while halted", cyc_o, 3);

        // R9: jump beyond the program
        load_prog(200);
        pulse(1'b0, 1'b1, 4'd1, 8'd250, 1'b0, 1'b0, 1'b0, '0, '0);
        check("R9", "halt after jump out", halt_o, 1);
        check("R3", "pc after jump out", pc_o, 250);

        // R11: load and step together
        load_prog(200);
        nop_step(); nop_step();
        prog_len_i = 9'd200;
        pulse(1'b1, 1'b1, 4'd1, 8'd80, 1'b0, 1'b0, 1'b0, '0, '0);
        check("R11", "pc when load meets step", pc_o, 0);
        check("R11", "count when load meets step", cyc_o, 0);

        // R10: count saturates at the ceiling and halts
        load_prog(200);
        for (int k = 0; k < MAXC - 1; k++) nop_step();
        check("R10", "no halt below ceiling", halt_o, 0);
        nop_step();
        check("R10", "count at ceiling", cyc_o, MAXC);
        check("R10", "halt at ceiling", halt_o, 1);
        nop_step();
        check("R10", "count holds at ceiling", cyc_o, MAXC);
        check("R10", "pc holds at ceiling", pc_o, MAXC);

        done = 1'b1;
        report();
    end

endmodule